// File: doc/BRIEF.md
# Load/Store Address Generator

This block sits between the issue stage of a load/store pipeline and a 32-bit data memory. For each request it works out the byte address to access and the new pointer value, using a base pointer, a step given in elements (default one element, a 5-bit unsigned constant, or an offset register), a direction and an addressing kind. The step is scaled by the access size: 1 for byte, 2 for halfword, 4 for word. The pointer write-back leaves the block in the same cycle as the request, so a following instruction can use the updated pointer at once. It does not wait for the load data.

The block also drives the four byte-lane enables, places store data onto the right lanes, and records each load's lane, size and extension in a fixed-latency pipeline. When the memory word returns, the block selects the right lanes and sign- or zero-extends the result to 32 bits. Either byte order can be selected per request.

Top module: `mem_agu`

## Requirements
- R1: With kind OFFSET (code 0) and no displacement, `mem_addr` equals `req_base` and `ptr_wb_en` is 0.
- R2: With kind PRE (code 1), `mem_addr` is the modified pointer, `ptr_wb_en` is 1 and `ptr_wb_val` equals `mem_addr`.
- R3: With kind POST (code 2), `mem_addr` equals `req_base`, `ptr_wb_en` is 1 and `ptr_wb_val` is the modified pointer.
- R4: The element step is multiplied by 1, 2 or 4 for size codes 0 (byte), 1 (halfword) and 2 (word). Size code 3 acts as word.
- R5: When `req_has_disp` is 0, PRE and POST step by one element. When it is 1, the step is `req_imm5` (unsigned, 0..31) if `req_disp_reg` is 0, or `req_offreg` if it is 1.
- R6: With `req_neg` set, the scaled step is subtracted from the base, modulo 2^AW. Otherwise it is added.
- R7: Kind OFFSET with a displacement, and the reserved kind code 3, access base plus or minus the scaled step and never write the pointer back.
- R8: Little-endian (`big_endian`=0): bit k of `mem_ben` covers data bits 8k+7:8k. A byte access at address offset o enables lane o. A halfword enables lanes {2h+1,2h}, where h is address bit 1. A word enables all four lanes. Address bits below the access size do not affect the lanes.
- R9: Big-endian: a byte at offset o uses lane 3-o. A halfword with address bit 1 equal to 0 uses lanes 3:2, and with bit 1 equal to 1 uses lanes 1:0.
- R10: A store (`req_load`=0) raises `mem_we` and drives the low byte or halfword of `req_wdata` onto its enabled lanes, with zeros elsewhere. A word store drives `req_wdata` unchanged. A load keeps `mem_we` at 0.
- R11: Exactly LOAD_LAT cycles after a load is issued, `ld_valid` is 1 for one cycle. `ld_data` is then the selected byte or halfword of `mem_rdata`, sign-extended if `req_signed` was 1 at issue and zero-extended otherwise. `ld_valid` is 0 in all other cycles.
- R12: While `rst_n` is low, `mem_en`, `ptr_wb_en` and `ld_valid` are 0 and requests are dropped.
- R13: A word load returns `mem_rdata` unchanged, whatever `req_signed` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_load | input | 1 | 1 = load, 0 = store |
| req_kind | input | 2 | 0 OFFSET, 1 PRE, 2 POST, 3 reserved (as OFFSET) |
| req_neg | input | 1 | Subtract the step instead of adding it |
| req_has_disp | input | 1 | An explicit displacement is supplied |
| req_disp_reg | input | 1 | Displacement comes from `req_offreg` instead of `req_imm5` |
| req_imm5 | input | 5 | Unsigned constant displacement in elements |
| req_base | input | AW | Base pointer value |
| req_offreg | input | AW | Offset register value in elements |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_signed | input | 1 | Sign-extend a sub-word load |
| req_wdata | input | 32 | Store data, right-justified |
| big_endian | input | 1 | Byte order for this request |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Byte address of the access |
| mem_ben | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Store data on its lanes |
| mem_rdata | input | 32 | Read word, LOAD_LAT cycles after issue |
| ptr_wb_en | output | 1 | Pointer write-back strobe |
| ptr_wb_val | output | AW | Updated pointer value |
| ld_valid | output | 1 | Aligned load data valid |
| ld_data | output | 32 | Aligned, extended load data |

## Verification
The bench targets the cases where pre- and post-modify are easily confused: a POST design that accessed the modified address would read the wrong word and be caught at once. It tries unscaled steps (a halfword step of 3 must move by 6), the default one-element step, and a missing or wrong default would leave the pointer fixed or move it too far. Subtraction that wraps below zero, and the reserved kind, which must never write back, are both tried. The lane mapping in both byte orders and sign-extension of bytes and halfwords are checked against a behavioural memory. A swapped lane or a lost sign bit shows up as a wrong `ld_data` exactly LOAD_LAT cycles after the load. Requests made during reset must leave no load in flight.

// File: rtl/agu_pkg.sv
package agu_pkg;

  localparam int NLANES = 4;
  localparam int LANE_IDX_W = $clog2(NLANES);

  typedef enum logic [1:0] {
    KIND_OFFSET = 2'd0,
    KIND_PRE    = 2'd1,
    KIND_POST   = 2'd2,
    KIND_RSVD   = 2'd3
  } agu_kind_e;

  typedef struct packed {
    logic [LANE_IDX_W-1:0] lane;
    logic [1:0]            shift;
    logic                  sext;
  } ld_desc_t;

  // log2 of the element size in bytes; code 3 is treated as a word
  function automatic logic [1:0] size_shift(input logic [1:0] sz);
    return (sz == 2'd3) ? 2'd2 : sz;
  endfunction

  // lowest data-bus lane touched by the access
  function automatic logic [LANE_IDX_W-1:0] first_lane(input logic [1:0] shift,
                                                       input logic [1:0] off,
                                                       input logic       be);
    logic [LANE_IDX_W-1:0] l;
    case (shift)
      2'd0:    l = be ? ~off : off;
      2'd1:    l = be ? {~off[1], 1'b0} : {off[1], 1'b0};
      default: l = '0;
    endcase
    return l;
  endfunction

  function automatic logic [NLANES-1:0] lane_mask(input logic [1:0] shift);
    case (shift)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  // select lanes from a bus word and extend them
  function automatic logic [31:0] extract(input logic [31:0] word,
                                          input ld_desc_t d);
    logic [31:0] s;
    s = word >> {d.lane, 3'b000};
    case (d.shift)
      2'd0:    return d.sext ? {{24{s[7]}}, s[7:0]} : {24'd0, s[7:0]};
      2'd1:    return d.sext ? {{16{s[15]}}, s[15:0]} : {16'd0, s[15:0]};
      default: return word;
    endcase
  endfunction

endpackage

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
  import agu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic [1:0]    kind,
  input  logic          neg,
  input  logic          has_disp,
  input  logic          disp_reg,
  input  logic [4:0]    imm5,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] offreg,
  input  logic [1:0]    size,
  output logic [AW-1:0] addr,
  output logic          wb_en,
  output logic [AW-1:0] wb_val
);

  logic          is_pre, is_post, modifies;
  logic          step_is_default;
  logic [AW-1:0] step_elems;
  logic [AW-1:0] step_bytes;
  logic [AW-1:0] moved_ptr;

  assign is_pre          = (agu_kind_e'(kind) == KIND_PRE);
  assign is_post         = (agu_kind_e'(kind) == KIND_POST);
  assign modifies        = is_pre | is_post;
  assign step_is_default = ~has_disp;

  always_comb begin
    if (has_disp)
      step_elems = disp_reg ? offreg : {{(AW-5){1'b0}}, imm5};
    else
      step_elems = modifies ? {{(AW-1){1'b0}}, 1'b1} : '0;
  end

  assign step_bytes = step_elems << size_shift(size);
  assign moved_ptr  = neg ? (base - step_bytes) : (base + step_bytes);

  assign addr   = is_post ? base : moved_ptr;
  assign wb_en  = valid & modifies;
  assign wb_val = moved_ptr;

  AST_PRE_ACCESS_IS_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && is_pre) |-> (wb_en && addr == wb_val)); // R2
  AST_POST_ACCESS_IS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && is_post) |-> (wb_en && addr == base)); // R3
  AST_OFFSET_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !modifies) |-> !wb_en); // R7
  AST_DEFAULT_ONE_ELEM: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && step_is_default && !neg) |-> ((wb_val - base) == (AW'(1) << size_shift(size)))); // R5

endmodule

// File: rtl/agu_lane_map.sv
module agu_lane_map
  import agu_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [1:0]            size,
  input  logic [1:0]            addr_lo,
  input  logic                  big_endian,
  input  logic [31:0]           wdata_in,
  output logic [NLANES-1:0]     ben,
  output logic [LANE_IDX_W-1:0] lane,
  output logic [31:0]           wdata_out
);

  logic [1:0]  shift;
  logic [31:0] justified;
  logic [31:0] lane_bits;

  assign shift = size_shift(size);
  assign lane  = first_lane(shift, addr_lo, big_endian);
  assign ben   = lane_mask(shift) << lane;

  always_comb begin
    case (shift)
      2'd0:    justified = {24'd0, wdata_in[7:0]};
      2'd1:    justified = {16'd0, wdata_in[15:0]};
      default: justified = wdata_in;
    endcase
  end

  assign wdata_out = justified << {lane, 3'b000};

  for (genvar k = 0; k < NLANES; k++) begin : g_lane_bits
    assign lane_bits[8*k +: 8] = {8{ben[k]}};
  end

  AST_BEN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ($countones(ben) == (32'(1) << shift))); // R8
  AST_WDATA_IN_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ((wdata_out & ~lane_bits) == 32'd0)); // R10

endmodule

// File: rtl/agu_load_align.sv
module agu_load_align
  import agu_pkg::*;
#(
  parameter int LOAD_LAT = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  issue,
  input  logic [LANE_IDX_W-1:0] lane,
  input  logic [1:0]            shift,
  input  logic                  sext,
  input  logic [31:0]           rdata,
  output logic                  ld_valid,
  output logic [31:0]           ld_data
);

  ld_desc_t desc_chain [LOAD_LAT+1];
  logic     vld_chain  [LOAD_LAT+1];
  ld_desc_t head;

  assign desc_chain[0] = '{lane: lane, shift: shift, sext: sext};
  assign vld_chain[0]  = issue;

  for (genvar g = 0; g < LOAD_LAT; g++) begin : g_stage
    ld_desc_t desc_q;
    logic     vld_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        desc_q <= '0;
      end else begin
        vld_q  <= vld_chain[g];
        desc_q <= desc_chain[g];
      end
    end
    assign vld_chain[g+1]  = vld_q;
    assign desc_chain[g+1] = desc_q;
  end

  assign head     = desc_chain[LOAD_LAT];
  assign ld_valid = vld_chain[LOAD_LAT];
  assign ld_data  = extract(rdata, head);

  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && head.shift == 2'd0 && !head.sext) |-> (ld_data[31:8] == 24'd0)); // R11
  AST_HALF_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && head.shift == 2'd1 && head.sext) |-> (ld_data[31:16] == {16{ld_data[15]}})); // R11
  AST_WORD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && head.shift[1]) |-> (ld_data == rdata)); // R13

endmodule

// File: rtl/mem_agu.sv
module mem_agu
  import agu_pkg::*;
#(
  parameter int AW       = 32,
  parameter int LOAD_LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_load,
  input  logic [1:0]    req_kind,
  input  logic          req_neg,
  input  logic          req_has_disp,
  input  logic          req_disp_reg,
  input  logic [4:0]    req_imm5,
  input  logic [AW-1:0] req_base,
  input  logic [AW-1:0] req_offreg,
  input  logic [1:0]    req_size,
  input  logic          req_signed,
  input  logic [31:0]   req_wdata,
  input  logic          big_endian,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_ben,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          ptr_wb_en,
  output logic [AW-1:0] ptr_wb_val,
  output logic          ld_valid,
  output logic [31:0]   ld_data
);

  logic                  issue;
  logic                  load_issue;
  logic [LANE_IDX_W-1:0] lane_sel;

  assign issue      = req_valid & rst_n;
  assign load_issue = issue & req_load;

  agu_addr_calc #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (issue),
    .kind     (req_kind),
    .neg      (req_neg),
    .has_disp (req_has_disp),
    .disp_reg (req_disp_reg),
    .imm5     (req_imm5),
    .base     (req_base),
    .offreg   (req_offreg),
    .size     (req_size),
    .addr     (mem_addr),
    .wb_en    (ptr_wb_en),
    .wb_val   (ptr_wb_val)
  );

  agu_lane_map u_lanes (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (issue),
    .size       (req_size),
    .addr_lo    (mem_addr[1:0]),
    .big_endian (big_endian),
    .wdata_in   (req_wdata),
    .ben        (mem_ben),
    .lane       (lane_sel),
    .wdata_out  (mem_wdata)
  );

  agu_load_align #(.LOAD_LAT(LOAD_LAT)) u_align (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (load_issue),
    .lane     (lane_sel),
    .shift    (size_shift(req_size)),
    .sext     (req_signed),
    .rdata    (mem_rdata),
    .ld_valid (ld_valid),
    .ld_data  (ld_data)
  );

  assign mem_en = issue;
  assign mem_we = issue & ~req_load;

  AST_RESET_SILENT: assert property (@(posedge clk)
    !rst_n |-> (!mem_en && !ptr_wb_en)); // R12

endmodule

// File: tb/mem_agu_tb.sv
module mem_agu_tb;

  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_load, req_neg, req_has_disp, req_disp_reg, req_signed, big_endian;
  logic [1:0]  req_kind, req_size;
  logic [4:0]  req_imm5;
  logic [31:0] req_base, req_offreg, req_wdata, mem_rdata;
  logic        mem_en, mem_we, ptr_wb_en, ld_valid;
  logic [31:0] mem_addr, mem_wdata, ptr_wb_val, ld_data;
  logic [3:0]  mem_ben;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  typedef struct {
    int          due;
    logic [31:0] addr;
    int          nbytes;
    bit          sgn;
    bit          be;
  } pend_t;
  pend_t pend[$];

  always #4 clk = ~clk;

  mem_agu #(.AW(32), .LOAD_LAT(LAT)) u_dut (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return ((a >> 2) * 32'h9E3779B1) ^ 32'hC3A50F96;
  endfunction

  function automatic int nbytes_of(input logic [1:0] sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic int start_lane(input logic [31:0] a, input int nb, input bit be);
    int off = int'(a[1:0]);
    if (nb == 1) return be ? 3 - off : off;
    if (nb == 2) return be ? 2 - (off / 2) * 2 : (off / 2) * 2;
    return 0;
  endfunction

  // reference address arithmetic from the requirements
  task automatic model(output logic [31:0] addr, output bit wb, output logic [31:0] wbv);
    longint step;
    longint moved;
    bit pre = (req_kind == 1);
    bit post = (req_kind == 2);
    if (req_has_disp) step = req_disp_reg ? longint'(req_offreg) : longint'(req_imm5);
    else step = (pre || post) ? 1 : 0;
    step = step * nbytes_of(req_size);
    moved = req_neg ? longint'(req_base) - step : longint'(req_base) + step;
    wbv = moved[31:0];
    wb = pre || post;
    addr = post ? req_base : wbv;
  endtask

  task automatic tick();
    logic [31:0] e_addr, e_wbv, e_ld, w;
    bit e_wb, due_now;
    int nb, sl;
    string t;
    pend_t p;
    due_now = (pend.size() > 0) && (pend[0].due == cyc);
    if (due_now) begin
      p = pend.pop_front();
      w = mem_word(p.addr);
      mem_rdata = w;
      sl = start_lane(p.addr, p.nbytes, p.be);
      e_ld = w >> (8 * sl);
      if (p.nbytes == 1) e_ld = p.sgn ? {{24{e_ld[7]}}, e_ld[7:0]} : {24'd0, e_ld[7:0]};
      else if (p.nbytes == 2) e_ld = p.sgn ? {{16{e_ld[15]}}, e_ld[15:0]} : {16'd0, e_ld[15:0]};
    end else begin
      mem_rdata = $urandom;
    end
    #1;
    if (due_now) begin
      chk(32'(ld_valid), 1, "R11", "ld_valid at due cycle");
      chk(ld_data, e_ld, (p.nbytes == 4) ? "R13" : "R11", "ld_data");
    end else begin
      chk(32'(ld_valid), 0, rst_n ? "R11" : "R12", "ld_valid idle");
    end
    if (!rst_n) begin
      chk(32'(mem_en), 0, "R12", "mem_en in reset");
      chk(32'(ptr_wb_en), 0, "R12", "ptr_wb_en in reset");
    end else if (req_valid) begin
      model(e_addr, e_wb, e_wbv);
      nb = nbytes_of(req_size);
      if (req_kind == 1) t = "R2";
      else if (req_kind == 2) t = "R3";
      else if (req_has_disp || req_kind == 3) t = "R7";
      else t = "R1";
      chk(32'(mem_en), 1, "R10", "mem_en");
      chk(mem_addr, e_addr, t, "mem_addr");
      chk(32'(ptr_wb_en), 32'(e_wb), t, "ptr_wb_en");
      if (e_wb) chk(ptr_wb_val, e_wbv, t, "ptr_wb_val");
      sl = start_lane(e_addr, nb, big_endian);
      chk(32'(mem_ben), ((1 << nb) - 1) << sl, big_endian ? "R9" : "R8", "mem_ben");
      chk(32'(mem_we), 32'(!req_load), "R10", "mem_we");
      if (!req_load) begin
        w = (nb == 1) ? (req_wdata & 32'hFF) : (nb == 2) ? (req_wdata & 32'hFFFF) : req_wdata;
        chk(mem_wdata, w << (8 * sl), "R10", "mem_wdata");
      end else begin
        pend.push_back('{due: cyc + LAT, addr: e_addr, nbytes: nb, sgn: req_signed, be: big_endian});
      end
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  task automatic drive(input bit v, input bit ld, input logic [1:0] kind, input bit ng,
                       input bit hd, input bit dr, input logic [4:0] imm, input logic [31:0] base,
                       input logic [31:0] off, input logic [1:0] sz, input bit sg,
                       input logic [31:0] wd, input bit be);
    req_valid = v; req_load = ld; req_kind = kind; req_neg = ng; req_has_disp = hd;
    req_disp_reg = dr; req_imm5 = imm; req_base = base; req_offreg = off; req_size = sz;
    req_signed = sg; req_wdata = wd; big_endian = be;
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R11 watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    mem_rdata = '0;
    drive(0, 1, 0, 0, 0, 0, 0, 0, 0, 2, 0, 0, 0);
    @(negedge clk);
    // R12: requests during reset are dropped
    for (int i = 0; i < 4; i++) begin
      drive(1, 1, 1, 0, 0, 0, 0, 32'h100, 0, 2, 0, 0, 0);
      tick();
    end
    rst_n = 1'b1;

    // R1 plain pointer access
    drive(1, 1, 0, 0, 0, 0, 0, 32'h108, 0, 2, 0, 0, 0);
    chk(mem_addr, 32'h108, "R1", "plain addr");
    chk(32'(ptr_wb_en), 0, "R1", "plain no wb");
    tick();
    // R2 and R4 pre-increment by one word
    drive(1, 1, 1, 0, 1, 0, 1, 32'h108, 0, 2, 0, 0, 0);
    chk(mem_addr, 32'h10C, "R2", "pre addr");
    chk(ptr_wb_val, 32'h10C, "R4", "word scale");
    tick();
    // R3 post-increment
    drive(1, 1, 2, 0, 1, 0, 1, 32'h108, 0, 2, 0, 0, 0);
    chk(mem_addr, 32'h108, "R3", "post addr");
    chk(ptr_wb_val, 32'h10C, "R3", "post wb");
    tick();
    // R4 halfword and byte scaling
    drive(1, 1, 1, 0, 1, 0, 3, 32'h100, 0, 1, 1, 0, 0);
    chk(mem_addr, 32'h106, "R4", "half scale");
    tick();
    drive(1, 1, 1, 0, 1, 0, 3, 32'h100, 0, 0, 1, 0, 0);
    chk(mem_addr, 32'h103, "R4", "byte scale");
    tick();
    // R5 default step and register displacement
    drive(1, 1, 2, 0, 0, 0, 7, 32'h200, 0, 1, 0, 0, 0);
    chk(ptr_wb_val, 32'h202, "R5", "default one element");
    tick();
    drive(1, 1, 1, 0, 1, 1, 1, 32'h200, 32'h10, 2, 0, 0, 0);
    chk(mem_addr, 32'h240, "R5", "register displacement");
    tick();
    // R6 negative offset and wrap
    drive(1, 1, 0, 1, 1, 0, 1, 32'h108, 0, 2, 0, 0, 0);
    chk(mem_addr, 32'h104, "R6", "negative displacement");
    tick();
    drive(1, 1, 1, 1, 0, 0, 0, 32'h0, 0, 0, 1, 0, 0);
    chk(ptr_wb_val, 32'hFFFFFFFF, "R6", "wrap below zero");
    tick();
    // R7 reserved kind: offset access, no write-back
    drive(1, 1, 3, 0, 1, 0, 2, 32'h100, 0, 2, 0, 0, 0);
    chk(mem_addr, 32'h108, "R7", "reserved kind addr");
    chk(32'(ptr_wb_en), 0, "R7", "reserved kind no wb");
    tick();
    // R8 and R9 lanes
    drive(1, 1, 0, 0, 0, 0, 0, 32'h101, 0, 0, 1, 0, 0);
    chk(32'(mem_ben), 32'b0010, "R8", "LE byte lane");
    tick();
    drive(1, 1, 0, 0, 0, 0, 0, 32'h101, 0, 0, 1, 0, 1);
    chk(32'(mem_ben), 32'b0100, "R9", "BE byte lane");
    tick();
    drive(1, 1, 0, 0, 0, 0, 0, 32'h102, 0, 1, 1, 0, 1);
    chk(32'(mem_ben), 32'b0011, "R9", "BE half lane");
    tick();
    // R10 byte store on lane 3
    drive(1, 0, 0, 0, 0, 0, 0, 32'h103, 0, 0, 0, 32'hAABBCCDD, 0);
    chk(mem_wdata, 32'hDD000000, "R10", "byte store placement");
    chk(32'(mem_ben), 32'b1000, "R10", "byte store lane");
    tick();
    // drain
    drive(0, 1, 0, 0, 0, 0, 0, 0, 0, 2, 0, 0, 0);
    repeat (LAT + 1) tick();

    // random traffic
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] b, o;
      b = ($urandom_range(0, 7) == 0) ? $urandom : ($urandom & 32'hFFF);
      o = ($urandom_range(0, 3) == 0) ? $urandom : ($urandom & 32'h3F);
      drive(($urandom_range(0, 9) < 8), $urandom_range(0, 1), 2'($urandom), $urandom_range(0, 1),
            $urandom_range(0, 1), $urandom_range(0, 1), 5'($urandom), b, o, 2'($urandom),
            $urandom_range(0, 1), $urandom, $urandom_range(0, 1));
      tick();
    end
    drive(0, 1, 0, 0, 0, 0, 0, 0, 0, 2, 0, 0, 0);
    repeat (LAT + 2) tick();
    chk(32'(pend.size()), 0, "R11", "all loads returned");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule